// File: doc/BRIEF.md
# Directional Hysteresis Sample Slicer

This block turns a stream of signed samples into a three-valued trace: plus one, minus one or zero. A sample is marked plus one only when it sits at or above an upper threshold and has also climbed relative to the raw sample before it. It is marked minus one only when it sits at or below a lower threshold and has dropped relative to that previous raw sample. Every other sample repeats the level decided for the one before it. A sample that stays high but is falling therefore keeps its old mark, and so does one that stays low but is rising.

The level of the very first sample after reset or clear cannot be judged, because it has nothing to compare against. That first sample takes the level decided for the second one, so the output stream runs one sample behind the input. Each accepted sample after the first releases the level of its predecessor one clock later. Thresholds are plain inputs and are read on every accepted sample.

Top module: `directional_slicer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `out_valid` is 0 and `out_level` is 2'b00.
- R2: An accepted sample at or above `thr_hi` (signed, inclusive) and strictly greater than the previous accepted raw sample is given the level +1, encoded as 2'b01.
- R3: An accepted sample that does not meet R2, is at or below `thr_lo` (signed, inclusive) and is strictly less than the previous accepted raw sample is given the level -1, encoded as 2'b11.
- R4: An accepted sample that meets neither R2 nor R3 repeats the level of the sample before it. A sample equal to its predecessor always repeats.
- R5: Direction is judged against the previous raw sample only, never against the previous output level. A sample above `thr_hi` that is falling keeps the old level, and so does a sample below `thr_lo` that is rising.
- R6: The first accepted sample after reset or clear produces no output by itself. When the second sample is accepted, `out_valid` goes high on the next clock with the second sample's level, which stands for the first sample.
- R7: From then on, each accepted sample makes `out_valid` high for exactly one clock on the next cycle, carrying the level of the sample accepted before it. `out_valid` is never high except on the cycle after an accepted sample.
- R8: Cycles with `in_valid` low change no state. `out_valid` is 0 on the cycle that follows them, and `out_level` keeps its value.
- R9: `clr` high on a clock edge empties the stored sample, the held level and the first-sample state. On the next cycle `out_valid` is 0 and `out_level` is 2'b00. A sample offered in the same cycle as `clr` is dropped, and the next accepted sample counts as a first sample.
- R10: The held level starts at 0 (2'b00) after reset or clear. If the second sample meets neither R2 nor R3, the first two samples are both reported as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of the stream state, active high |
| in_valid | input | 1 | Input sample is offered this cycle |
| in_sample | input | DATA_W | Signed input sample |
| thr_hi | input | DATA_W | Signed upper threshold |
| thr_lo | input | DATA_W | Signed lower threshold |
| out_valid | output | 1 | Output level is valid this cycle |
| out_level | output | 2 | Level: 01 = +1, 11 = -1, 00 = 0 |

## Verification
Two events can meet in one cycle: a clear and an accepted sample, and also the first-sample substitution and a fresh decision. The bench raises `clr` while also offering a sample with `in_valid` high. It then expects an idle output and a zero level, and it expects the following two samples to behave as a new first and second pair. The substitution case is driven right after a clear with a second sample that crosses a threshold. The per-clock reference model must then see that level on both the stand-in output and the next one, with no zero leaking out from the initial held state.

// File: rtl/slicer_pkg.sv
package slicer_pkg;
  typedef enum logic [1:0] {
    PH_EMPTY  = 2'd0,
    PH_PRIMED = 2'd1,
    PH_RUN    = 2'd2
  } phase_e;

  localparam logic [1:0] LVL_ZERO  = 2'b00;
  localparam logic [1:0] LVL_PLUS  = 2'b01;
  localparam logic [1:0] LVL_MINUS = 2'b11;
endpackage

// File: rtl/slicer_history.sv
module slicer_history
  import slicer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     fire,
  input  logic signed [DATA_W-1:0] sample,
  output logic signed [DATA_W-1:0] prev_q,
  output phase_e                   phase_q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      prev_q  <= '0;
      phase_q <= PH_EMPTY;
    end else if (fire) begin
      prev_q  <= sample;
      phase_q <= (phase_q == PH_EMPTY) ? PH_PRIMED : PH_RUN;
    end
  end

  // R6: the phase only ever advances on an accepted sample
  p_phase_moves_on_sample_r6: assert property (@(posedge clk) disable iff (rst)
    (!fire && !clr) |=> $stable(phase_q));
endmodule

// File: rtl/slicer_compare.sv
module slicer_compare #(
  parameter int DATA_W = 8
) (
  input  logic signed [DATA_W-1:0] sample,
  input  logic signed [DATA_W-1:0] prev,
  input  logic signed [DATA_W-1:0] thr_hi,
  input  logic signed [DATA_W-1:0] thr_lo,
  output logic                     go_up,
  output logic                     go_down
);
  logic above, below, rising, falling;

  always_comb begin
    above   = (sample >= thr_hi);
    below   = (sample <= thr_lo);
    rising  = (sample > prev);
    falling = (sample < prev);
    go_up   = above && rising;
    go_down = below && falling;
  end
endmodule

// File: rtl/slicer_level.sv
module slicer_level
  import slicer_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        fire,
  input  phase_e      phase_q,
  input  logic        go_up,
  input  logic        go_down,
  output logic [1:0]  held_q,
  output logic        out_valid,
  output logic [1:0]  out_level
);
  logic [1:0] next_lvl;
  logic       decide;

  always_comb begin
    decide = fire && (phase_q != PH_EMPTY);
    if (go_up)        next_lvl = LVL_PLUS;
    else if (go_down) next_lvl = LVL_MINUS;
    else              next_lvl = held_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      held_q    <= LVL_ZERO;
      out_valid <= 1'b0;
      out_level <= LVL_ZERO;
    end else begin
      out_valid <= decide;
      if (decide) begin
        out_level <= (phase_q == PH_PRIMED) ? next_lvl : held_q;
        held_q    <= next_lvl;
      end
    end
  end

  // R2/R3: only the three defined codes ever leave the block
  p_legal_code_r2: assert property (@(posedge clk) disable iff (rst)
    out_level != 2'b10);

  // R8: an idle cycle leaves the held level untouched
  p_idle_keeps_level_r8: assert property (@(posedge clk) disable iff (rst)
    (!fire && !clr) |=> $stable(held_q));
endmodule

// File: rtl/directional_slicer.sv
module directional_slicer
  import slicer_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_sample,
  input  logic signed [DATA_W-1:0] thr_hi,
  input  logic signed [DATA_W-1:0] thr_lo,
  output logic                     out_valid,
  output logic [1:0]               out_level
);
  logic                     fire;
  logic signed [DATA_W-1:0] prev_q;
  phase_e                   phase_q;
  logic                     go_up, go_down;
  logic [1:0]               held_q;

  assign fire = in_valid && !clr;

  slicer_history #(.DATA_W(DATA_W)) u_hist (
    .clk(clk), .rst(rst), .clr(clr), .fire(fire),
    .sample(in_sample), .prev_q(prev_q), .phase_q(phase_q)
  );

  slicer_compare #(.DATA_W(DATA_W)) u_cmp (
    .sample(in_sample), .prev(prev_q), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .go_up(go_up), .go_down(go_down)
  );

  slicer_level u_lvl (
    .clk(clk), .rst(rst), .clr(clr), .fire(fire), .phase_q(phase_q),
    .go_up(go_up), .go_down(go_down), .held_q(held_q),
    .out_valid(out_valid), .out_level(out_level)
  );

  // R7: a valid output is always caused by a sample accepted one cycle earlier
  p_valid_after_sample_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(in_valid) && !$past(clr)));

  // R9: a clear silences the output on the following cycle
  p_clear_quiets_r9: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!out_valid && out_level == LVL_ZERO));

  // R2: a rising sample at or above the upper threshold becomes +1
  p_rise_marks_plus_r2: assert property (@(posedge clk) disable iff (rst)
    (fire && phase_q != PH_EMPTY && in_sample >= thr_hi && in_sample > prev_q)
      |=> held_q == LVL_PLUS);

  // R3: a falling sample at or below the lower threshold becomes -1
  p_fall_marks_minus_r3: assert property (@(posedge clk) disable iff (rst)
    (fire && phase_q != PH_EMPTY && !(in_sample >= thr_hi && in_sample > prev_q)
      && in_sample <= thr_lo && in_sample < prev_q) |=> held_q == LVL_MINUS);
endmodule

// File: tb/sim_directional_slicer.sv
module sim_directional_slicer;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst, clr, in_valid;
  logic signed [7:0] in_sample, thr_hi, thr_lo;
  logic              out_valid;
  logic [1:0]        out_level;

  directional_slicer #(.DATA_W(8)) u0 (
    .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid),
    .in_sample(in_sample), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .out_valid(out_valid), .out_level(out_level)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  int m_phase = 0;
  int m_prev  = 0;
  int m_held  = 0;
  bit e_valid = 0;
  int e_level = 0;

  function automatic logic [1:0] enc(int v);
    if (v > 0) return 2'b01;
    if (v < 0) return 2'b11;
    return 2'b00;
  endfunction

  task automatic model_edge();
    int s, lvl;
    s = int'(in_sample);
    if (rst || clr) begin
      m_phase = 0; m_prev = 0; m_held = 0; e_valid = 0; e_level = 0;
    end else if (in_valid) begin
      if (m_phase == 0) begin
        m_prev = s; m_phase = 1; e_valid = 0;
      end else begin
        if (s >= int'(thr_hi) && s > m_prev)      lvl = 1;
        else if (s <= int'(thr_lo) && s < m_prev) lvl = -1;
        else                                      lvl = m_held;
        e_level = (m_phase == 1) ? lvl : m_held;
        m_held  = lvl;
        m_prev  = s;
        m_phase = 2;
        e_valid = 1;
      end
    end else begin
      e_valid = 0;
    end
  endtask

  task automatic step(bit v, int s, string tag);
    in_valid  = v;
    in_sample = s[7:0];
    @(posedge clk);
    model_edge();
    @(negedge clk);
    n_cmp++;
    if (out_valid !== e_valid || out_level !== enc(e_level)) begin
      n_bad++;
      $display("FAIL %s: valid/level actual %b/%b expected %b/%b",
               tag, out_valid, out_level, e_valid, enc(e_level));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; clr = 1'b0; in_valid = 1'b0; in_sample = '0;
    thr_hi = 8'sd40; thr_lo = -8'sd40;
    @(negedge clk);
    step(1, 77, "R1");
    step(0, 0, "R1");
    rst = 1'b0;
    step(0, 0, "R1");

    // R10: second sample crosses nothing, both first outputs are zero
    step(1, 0, "R10");
    step(1, 5, "R10");
    step(1, 6, "R10");
    step(0, 0, "R8");
    step(0, 0, "R8");

    // R9: clear collides with an offered sample
    clr = 1'b1;
    step(1, 99, "R9");
    clr = 1'b0;
    // R6: first sample takes the second one's level
    step(1, 10, "R6");
    step(1, 50, "R6");
    step(1, 60, "R2");
    step(1, 45, "R5");
    step(1, 45, "R4");
    step(1, 30, "R4");
    step(1, 40, "R2");
    step(0, 0, "R8");
    step(1, -30, "R5");
    step(1, -40, "R3");
    step(1, -50, "R3");
    step(1, -45, "R5");
    step(1, -45, "R4");
    step(1, 0, "R4");
    step(1, 0, "R7");

    // R7: long mixed stream with gaps, clears and threshold moves
    for (int i = 0; i < 600; i++) begin
      clr = ($urandom_range(0, 49) == 0);
      if ($urandom_range(0, 63) == 0) begin
        thr_hi = 8'($urandom_range(0, 100));
        thr_lo = 8'(-int'($urandom_range(0, 100)));
      end
      step($urandom_range(0, 3) != 0, int'($urandom_range(0, 255)) - 128, "R7");
    end
    clr = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule